// File: doc/BRIEF.md
# Versioned Device Configuration Window

This block holds a small device-specific configuration memory that a driver reaches through a simple word-wide register bus, together with a read-only generation word. The driver uses the generation word to detect torn reads of multi-word configuration. It reads the generation word, then reads as many configuration words as it needs, then reads the generation word again. If the two generation values differ, the driver discards what it read and retries.

The device core changes configuration words through its own update lanes. A cycle that carries updates, or a run of cycles held together as one atomic batch, moves the generation word forward by exactly one. The generation word only counts upward, wrapping modulo 2^GEN_W. It never returns to an earlier value after a change, so a word that changes and then changes back is still detected.

Driver writes into the configuration region are accepted and do not move the generation word. Any other register decode lives elsewhere.

Top module: `cfg_gen_space`

## Requirements
- R1: After reset the generation word reads 0, every configuration word reads 0 and `bus_rvalid` is low.
- R2: A read request returns its data on `bus_rdata` with `bus_rvalid` high in the following cycle. Byte address 0x0FC returns the generation word. Address bits [1:0] are ignored, so 0x0FD also returns the generation word.
- R3: A driver write to byte address 0x100+4k updates configuration word k. `bus_be[i]` enables bits [8i+7:8i] of the word.
- R4: Writes to 0x0FC and to any address outside 0x100 .. 0x100+4*NWORDS-1 change nothing. Reads of such addresses, other than 0x0FC, return 0.
- R5: Each cycle outside a batch in which any update lane is valid advances the generation word by exactly one, however many lanes are valid in that cycle.
- R6: When several lanes write the same word in one cycle, the highest-numbered lane wins. A device update overrides a driver write to the same word in the same cycle.
- R7: While `upd_hold` is high the generation word does not change. In the first cycle with `upd_hold` low it advances by one if any update happened during the batch. If no update happened during the batch, it does not advance.
- R8: A word that is changed and then restored to its old value still leaves the generation word at a different, higher value.
- R9: A read in the same cycle as a device update returns the updated word. A generation read in that cycle returns the advanced generation value.
- R10: Driver writes to the configuration region do not change the generation word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_be | input | 4 | Byte enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| upd_valid | input | NLANES | Per-lane device update strobe |
| upd_idx | input | NLANES*IDX_W | Per-lane target word index |
| upd_data | input | NLANES*32 | Per-lane new word value |
| upd_hold | input | 1 | Keeps the current device updates in one atomic batch |

## Verification
The bench exercises several corner cases. The first is a word that is changed and then restored between two generation reads: a design that derived the generation value from the contents, or let it wrap back, would report no change. The second is two lanes valid in the same cycle, and a three-cycle held batch: a counter that stepped per lane or per cycle would advance by two or three, not one. A read that coincides with an update must see the new word and the advanced generation value; a design that read from the stored state would return stale data for one access. Byte enables, writes to the read-only word and address bits [1:0] are checked as well, since mistakes there would corrupt neighbouring bytes or let a driver forge the generation value.

// File: rtl/cfggen_pkg.sv
package cfggen_pkg;
   localparam int unsigned WORD_W     = 32;
   localparam int unsigned WORD_BYTES = WORD_W / 8;
   localparam int unsigned GEN_BYTE   = 32'h0FC;
   localparam int unsigned CFG_BYTE   = 32'h100;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode
   import cfggen_pkg::*;
#(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned NWORDS = 8,
   parameter int unsigned IDX_W  = 3
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              gen_hit,
   output logic              cfg_hit,
   output logic [IDX_W-1:0]  idx
);
   localparam int unsigned WA_W = ADDR_W - 2;
   localparam logic [WA_W-1:0] GEN_WA = WA_W'(GEN_BYTE >> 2);
   localparam logic [WA_W-1:0] CFG_WA = WA_W'(CFG_BYTE >> 2);
   localparam logic [WA_W-1:0] SPAN   = WA_W'(NWORDS);

   logic [WA_W-1:0] waddr;
   logic [WA_W-1:0] rel;
   logic [1:0]      unused_lo;

   assign waddr     = addr[ADDR_W-1:2];
   assign unused_lo = addr[1:0];

   always_comb begin
      rel     = waddr - CFG_WA;
      gen_hit = (waddr == GEN_WA);
      cfg_hit = (waddr >= CFG_WA) && (rel < SPAN);
      idx     = rel[IDX_W-1:0];
   end
endmodule

// File: rtl/cfg_word_array.sv
module cfg_word_array
   import cfggen_pkg::*;
#(
   parameter int unsigned NWORDS = 8,
   parameter int unsigned NLANES = 2,
   parameter int unsigned IDX_W  = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [IDX_W-1:0]         wr_idx,
   input  logic [WORD_BYTES-1:0]    wr_be,
   input  logic [WORD_W-1:0]        wr_data,
   input  logic [NLANES-1:0]        upd_valid,
   input  logic [NLANES*IDX_W-1:0]  upd_idx,
   input  logic [NLANES*WORD_W-1:0] upd_data,
   output logic [WORD_W-1:0]        words_q [NWORDS],
   output logic [WORD_W-1:0]        words_d [NWORDS]
);
   for (genvar w = 0; w < NWORDS; w++) begin : g_word
      logic [WORD_W-1:0] q;
      logic [WORD_W-1:0] nxt;

      always_comb begin
         nxt = q;
         if (wr_en && (wr_idx == IDX_W'(w))) begin
            for (int b = 0; b < WORD_BYTES; b++) begin
               if (wr_be[b]) nxt[8*b +: 8] = wr_data[8*b +: 8];
            end
         end
         // later lanes overwrite earlier ones: highest lane wins
         for (int l = 0; l < NLANES; l++) begin
            if (upd_valid[l] && (upd_idx[l*IDX_W +: IDX_W] == IDX_W'(w)))
               nxt = upd_data[l*WORD_W +: WORD_W];
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) q <= '0;
         else        q <= nxt;
      end

      assign words_q[w] = q;
      assign words_d[w] = nxt;
   end

   logic [IDX_W-1:0]  top_idx;
   logic [WORD_W-1:0] top_dat;
   assign top_idx = upd_idx[(NLANES-1)*IDX_W +: IDX_W];
   assign top_dat = upd_data[(NLANES-1)*WORD_W +: WORD_W];

   // R6
   top_lane_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid[NLANES-1] && (int'(top_idx) < NWORDS))
      |=> (words_q[$past(top_idx)] == $past(top_dat)));
endmodule

// File: rtl/gen_tracker.sv
module gen_tracker #(
   parameter int unsigned GEN_W   = 32,
   parameter bit          HOLD_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             upd_any,
   input  logic             hold,
   output logic [GEN_W-1:0] gen_q,
   output logic [GEN_W-1:0] gen_d
);
   logic bump;
   logic pending_q;

   if (HOLD_EN) begin : g_batch
      always_comb bump = !hold && (upd_any || pending_q);
      always_ff @(posedge clk) begin
         if (!rst_n)    pending_q <= 1'b0;
         else if (hold) pending_q <= pending_q || upd_any;
         else           pending_q <= 1'b0;
      end
   end else begin : g_direct
      logic unused_hold;
      assign unused_hold = hold;
      always_comb bump = upd_any;
      always_ff @(posedge clk) pending_q <= 1'b0;
   end

   assign gen_d = gen_q + GEN_W'(bump);

   always_ff @(posedge clk) begin
      if (!rst_n) gen_q <= '0;
      else        gen_q <= gen_d;
   end

   // R5 R8
   gen_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gen_q == $past(gen_q) + GEN_W'(1)) || (gen_q == $past(gen_q)));
   // R5
   upd_bump_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_any && !(HOLD_EN && hold)) |=> (gen_q != $past(gen_q)));
   // R7
   hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (HOLD_EN && hold) |=> $stable(gen_q));
endmodule

// File: rtl/cfg_gen_space.sv
module cfg_gen_space
   import cfggen_pkg::*;
#(
   parameter int unsigned NWORDS  = 8,
   parameter int unsigned NLANES  = 2,
   parameter int unsigned ADDR_W  = 12,
   parameter int unsigned GEN_W   = 32,
   parameter bit          HOLD_EN = 1'b1,
   localparam int unsigned IDX_W  = idx_width(NWORDS)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     bus_req,
   input  logic                     bus_we,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic [3:0]               bus_be,
   input  logic [31:0]              bus_wdata,
   output logic [31:0]              bus_rdata,
   output logic                     bus_rvalid,
   input  logic [NLANES-1:0]        upd_valid,
   input  logic [NLANES*IDX_W-1:0]  upd_idx,
   input  logic [NLANES*32-1:0]     upd_data,
   input  logic                     upd_hold
);
   initial begin
      if (ADDR_W < 10 || (CFG_BYTE + WORD_BYTES*NWORDS) > (64'd1 << ADDR_W) ||
          NWORDS < 1 || NLANES < 1 || GEN_W < 2 || GEN_W > WORD_W)
         $fatal(1, "cfg_gen_space: parameter set out of range");
   end

   logic              gen_hit;
   logic              cfg_hit;
   logic [IDX_W-1:0]  idx;
   logic [WORD_W-1:0] words_q [NWORDS];
   logic [WORD_W-1:0] words_d [NWORDS];
   logic [GEN_W-1:0]  gen_q;
   logic [GEN_W-1:0]  gen_d;
   logic [WORD_W-1:0] rd_d;
   logic              wr_en;

   cfg_addr_decode #(.ADDR_W(ADDR_W), .NWORDS(NWORDS), .IDX_W(IDX_W)) u_dec (
      .addr(bus_addr), .gen_hit(gen_hit), .cfg_hit(cfg_hit), .idx(idx));

   assign wr_en = bus_req && bus_we && cfg_hit;

   cfg_word_array #(.NWORDS(NWORDS), .NLANES(NLANES), .IDX_W(IDX_W)) u_arr (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(idx), .wr_be(bus_be),
      .wr_data(bus_wdata), .upd_valid(upd_valid), .upd_idx(upd_idx),
      .upd_data(upd_data), .words_q(words_q), .words_d(words_d));

   gen_tracker #(.GEN_W(GEN_W), .HOLD_EN(HOLD_EN)) u_gen (
      .clk(clk), .rst_n(rst_n), .upd_any(|upd_valid), .hold(upd_hold),
      .gen_q(gen_q), .gen_d(gen_d));

   // reads see the post-edge state so a coincident update is never missed
   always_comb begin
      if (gen_hit)      rd_d = WORD_W'(gen_d);
      else if (cfg_hit) rd_d = words_d[idx];
      else              rd_d = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rvalid <= 1'b0;
         bus_rdata  <= '0;
      end else begin
         bus_rvalid <= bus_req && !bus_we;
         if (bus_req && !bus_we) bus_rdata <= rd_d;
      end
   end

   // R2
   rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_we) |=> bus_rvalid);
   // R2
   rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_req && !bus_we) |=> !bus_rvalid);

   for (genvar w = 0; w < NWORDS; w++) begin : g_ro
      // R4
      ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_req && bus_we && !cfg_hit && !(|upd_valid)) |=> $stable(words_q[w]));
   end
endmodule

// File: tb/cfg_gen_space_bench.sv
`timescale 1ns/1ps
module cfg_gen_space_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_req = 1'b0, bus_we = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [3:0]  bus_be = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_rvalid;
   logic [1:0]  upd_valid = '0;
   logic [5:0]  upd_idx = '0;
   logic [63:0] upd_data = '0;
   logic        upd_hold = 1'b0;
   int n_chk = 0, n_bad = 0;

   always #4 clk = ~clk;

   cfg_gen_space u_cfg_gen_space (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .upd_valid(upd_valid),
      .upd_idx(upd_idx), .upd_data(upd_data), .upd_hold(upd_hold));

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one bus/update cycle driven at negedge; outputs sampleable on return
   task automatic step(input logic rq, input logic we, input logic [11:0] a,
                       input logic [3:0] be, input logic [31:0] wd,
                       input logic [1:0] uv, input logic [5:0] ui,
                       input logic [63:0] ud, input logic h);
      bus_req = rq; bus_we = we; bus_addr = a; bus_be = be; bus_wdata = wd;
      upd_valid = uv; upd_idx = ui; upd_data = ud; upd_hold = h;
      @(negedge clk);
      bus_req = 1'b0; bus_we = 1'b0; upd_valid = '0;
   endtask

   task automatic rd(input string tag, input logic [11:0] a, input logic [31:0] exp);
      step(1, 0, a, 4'h0, 0, 2'b00, 0, 0, upd_hold);
      check(tag, bus_rdata, exp);
   endtask

   // op: 0 write, 1 read, 2 device update lane0 (addr = word index)
   localparam logic [77:0] VEC [16] = '{
      {2'd1, 12'h0FC, 32'h0,        32'h0},         // R1 generation after reset
      {2'd0, 12'h100, 32'h11111111, 32'h0},
      {2'd1, 12'h100, 32'h0,        32'h11111111},  // R3
      {2'd1, 12'h0FC, 32'h0,        32'h0},         // R10
      {2'd2, 12'h002, 32'hA5A5A5A5, 32'h0},
      {2'd1, 12'h0FC, 32'h0,        32'h1},         // R5
      {2'd1, 12'h108, 32'h0,        32'hA5A5A5A5},
      {2'd0, 12'h0FC, 32'hDEADBEEF, 32'h0},
      {2'd1, 12'h0FC, 32'h0,        32'h1},         // R4
      {2'd1, 12'h200, 32'h0,        32'h0},         // R4
      {2'd2, 12'h002, 32'h0,        32'h0},
      {2'd2, 12'h002, 32'hA5A5A5A5, 32'h0},
      {2'd1, 12'h0FC, 32'h0,        32'h3},         // R8
      {2'd1, 12'h108, 32'h0,        32'hA5A5A5A5},  // R8
      {2'd0, 12'h11C, 32'hCAFEF00D, 32'h0},
      {2'd1, 12'h11C, 32'h0,        32'hCAFEF00D}   // R3
   };

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 rvalid", {31'b0, bus_rvalid}, 32'h0);
      rd("R1 word1", 12'h104, 32'h0);

      for (int i = 0; i < 16; i++) begin
         case (VEC[i][77:76])
            2'd0: step(1, 1, VEC[i][75:64], 4'hF, VEC[i][63:32], 2'b00, 0, 0, 0);
            2'd1: rd($sformatf("R2 table %0d", i), VEC[i][75:64], VEC[i][31:0]);
            default: step(0, 0, 0, 0, 0, 2'b01, {3'b0, VEC[i][66:64]},
                          {32'h0, VEC[i][63:32]}, 0);
         endcase
      end

      // R3 byte enables
      step(1, 1, 12'h104, 4'b0101, 32'hAABBCCDD, 2'b00, 0, 0, 0);
      rd("R3 byte enables", 12'h104, 32'h00BB00DD);

      // R5 two lanes, one bump
      step(0, 0, 0, 0, 0, 2'b11, {3'd4, 3'd3}, {32'd2, 32'd1}, 0);
      rd("R5 two lanes gen", 12'h0FC, 32'd4);
      rd("R5 lane0 word", 12'h10C, 32'd1);
      rd("R5 lane1 word", 12'h110, 32'd2);

      // R6 same word, lane1 wins
      step(0, 0, 0, 0, 0, 2'b11, {3'd5, 3'd5}, {32'h66, 32'h55}, 0);
      rd("R6 lane priority", 12'h114, 32'h66);
      // R6 device beats driver
      step(1, 1, 12'h118, 4'hF, 32'hFFFFFFFF, 2'b01, {3'd0, 3'd6}, {32'h0, 32'h12345678}, 0);
      rd("R6 device over driver", 12'h118, 32'h12345678);
      rd("R6 gen", 12'h0FC, 32'd6);

      // R7 batch
      step(0, 0, 0, 0, 0, 2'b01, {3'd0, 3'd7}, {32'h0, 32'h1}, 1);
      step(0, 0, 0, 0, 0, 2'b00, 0, 0, 1);
      step(0, 0, 0, 0, 0, 2'b01, {3'd0, 3'd7}, {32'h0, 32'h2}, 1);
      rd("R7 gen frozen in batch", 12'h0FC, 32'd6);
      upd_hold = 1'b0;
      rd("R7 gen on release", 12'h0FC, 32'd7);
      rd("R7 gen settled", 12'h0FC, 32'd7);
      rd("R7 batch data", 12'h11C, 32'h2);
      // R7 empty batch
      step(0, 0, 0, 0, 0, 2'b00, 0, 0, 1);
      upd_hold = 1'b0;
      rd("R7 empty batch", 12'h0FC, 32'd7);

      // R9 coincident reads
      step(1, 0, 12'h10C, 0, 0, 2'b01, {3'd0, 3'd3}, {32'h0, 32'h0BADF00D}, 0);
      check("R9 coincident word", bus_rdata, 32'h0BADF00D);
      step(1, 0, 12'h0FC, 0, 0, 2'b01, {3'd0, 3'd3}, {32'h0, 32'h3}, 0);
      check("R9 coincident gen", bus_rdata, 32'd9);
      rd("R9 word after", 12'h10C, 32'h3);

      // R2 ignored low address bits and valid timing
      rd("R2 unaligned gen", 12'h0FD, 32'd9);
      check("R2 rvalid high", {31'b0, bus_rvalid}, 32'h1);
      @(negedge clk);
      check("R2 rvalid low", {31'b0, bus_rvalid}, 32'h0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule